// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the clocked control front end of a burst-capable static RAM. It carries a small internal array so that it can be exercised on its own. On every rising clock edge it samples three chip enables, two address strobes, an advance input, a write-all input, a byte-write qualifier and one write strobe per byte. From these it decides whether the edge deselects the device, starts a new access, or continues the current burst.

On a start edge the block captures the address. The two lowest address bits become a burst counter that steps in linear order and wraps within four words. The upper address bits stay fixed for the whole burst. Writes take effect in the same edge. Reads return through a registered stage one clock later.

The read bus is driven only when the asynchronous output enable allows it. Drive is also held off for the first clock of a read that follows a deselected state.

Top module: `sburst_sram`

## Requirements
- R1: The device is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A start edge with any other enable combination deselects the device: no write occurs and `rdata_oe` is 0 from the following clock.
- R2: On a start edge the full address is captured, and `addr[1:0]` loads the burst counter. A read started on that edge shows the word at that address on `rdata` after that edge.
- R3: If both strobes are low on one edge, only `pstb_n` is honoured, so the cycle is a read.
- R4: `pstb_n` is ignored while `sel1_n`=1. An active burst then carries on as if no strobe was given.
- R5: On a non-start edge during an active burst with `adv_n`=0, the counter increments modulo 4 (order 0,1,2,3,0) and the upper address bits are unchanged. With `adv_n`=1 the address is held.
- R6: With `wall_n`=0, an access that may write stores every byte of `wdata`, whatever `bwq_n` and `bw_n` are.
- R7: With `wall_n`=1, a write occurs only when `bwq_n`=0, and only for the bytes whose `bw_n[i]`=0 (bit i covers `wdata[8i+7:8i]`). An access with no byte enabled is a read.
- R8: An access started by `pstb_n` is always a read. Write controls act only on edges started by `cstb_n` or on edges that continue a burst.
- R9: `rdata_oe` follows `oe_n` without a clock: it is 1 only while `oe_n`=0 and the last edge was a read.
- R10: On the clock after a read that starts from the deselected state, `rdata_oe` is 0 whatever `oe_n` is.
- R11: After reset the device is deselected, `rdata` is 0 and `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oe_n` are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel1_n | input | 1 | Chip enable 1, active low; also gates `pstb_n` |
| sel2 | input | 1 | Chip enable 2, active high |
| sel3_n | input | 1 | Chip enable 3, active low |
| pstb_n | input | 1 | Processor address strobe, active low, has priority |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wall_n | input | 1 | Write-all-bytes enable, active low |
| bwq_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | NB | Per-byte write strobes, active low |
| addr | input | AW | Word address |
| wdata | input | 8*NB | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 8*NB | Registered read data |
| rdata_oe | output | 1 | Read bus drive enable (1 = drive, 0 = bus is an input) |

## Verification
The bench first fills the whole array with four-word bursts that write all bytes. This gives every later read a known value and runs the wrap of the counter across each group. Directed patterns then set apart write-all from a partial byte write (one fixed byte pattern, checked against a literal merged word). They separate a write qualifier held inactive from a real write, both strobes low from the controller strobe alone, and a processor strobe with chip enable 1 high from a real restart. They also cover the first read after deselect and its masked drive from the reads that follow, and an output-enable toggle between edges from a clocked change. A long seeded random mix of enables, strobes, advance and write controls is then compared cycle by cycle with the bench's own memory model. This shows that the priority, gating and burst rules hold together in any order.

// File: rtl/sburst_sram.sv
module sburst_sram #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel1_n,
  input  logic            sel2,
  input  logic            sel3_n,
  input  logic            pstb_n,
  input  logic            cstb_n,
  input  logic            adv_n,
  input  logic            wall_n,
  input  logic            bwq_n,
  input  logic [NB-1:0]   bw_n,
  input  logic [AW-1:0]   addr,
  input  logic [8*NB-1:0] wdata,
  input  logic            oe_n,
  output logic [8*NB-1:0] rdata,
  output logic            rdata_oe
);
  localparam int DW    = 8 * NB;
  localparam int DEPTH = 1 << AW;
  localparam int UW    = AW - 2;

  logic [DW-1:0] mem [DEPTH];
  logic          active, rd_v, mask_q;
  logic [1:0]    cnt;
  logic [UW-1:0] upper;

  wire sel  = !sel1_n && sel2 && !sel3_n;
  wire p_go = !pstb_n && !sel1_n;
  wire c_go = !cstb_n && !p_go;
  wire go   = p_go || c_go;

  wire [1:0]    cnt_nx   = go ? addr[1:0] : ((active && !adv_n) ? cnt + 2'd1 : cnt);
  wire [UW-1:0] upper_nx = go ? addr[AW-1:2] : upper;
  wire          acc      = go ? sel : active;
  wire [NB-1:0] be       = !wall_n ? {NB{1'b1}} : (!bwq_n ? ~bw_n : '0);
  wire          wr       = acc && !p_go && (be != '0);
  wire          rd       = acc && !wr;
  wire [AW-1:0] cyc_addr = {upper_nx, cnt_nx};

  always_ff @(posedge clk) begin
    if (wr) begin
      for (int i = 0; i < NB; i++)
        if (be[i]) mem[cyc_addr][8*i +: 8] <= wdata[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      rd_v   <= 1'b0;
      mask_q <= 1'b0;
      cnt    <= '0;
      upper  <= '0;
      rdata  <= '0;
    end else begin
      active <= acc;
      rd_v   <= rd;
      mask_q <= rd && !active;
      cnt    <= cnt_nx;
      upper  <= upper_nx;
      if (rd) rdata <= mem[cyc_addr];
    end
  end

  assign rdata_oe = !oe_n && rd_v && !mask_q;

  a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !sel) |=> (!active && !rdata_oe));
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (go && sel) |=> (cnt == $past(addr[1:0]) && upper == $past(addr[AW-1:2])));
  a_r3_priority_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstb_n && !sel1_n && sel) |=> rd_v);
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && active && !adv_n) |=> (cnt == 2'($past(cnt) + 2'd1) && $stable(upper)));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && active && adv_n) |=> ($stable(cnt) && $stable(upper)));
  a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> !oe_n);
  a_r10_first_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !active) |=> !rdata_oe);
endmodule

// File: tb/sburst_sram_tb.sv
module sburst_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 8 * NB;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic sel1_n = 1, sel2 = 0, sel3_n = 1, pstb_n = 1, cstb_n = 1, adv_n = 1;
  logic wall_n = 1, bwq_n = 1, oe_n = 1;
  logic [NB-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic m_act = 0, m_rv = 0, m_mask = 0;
  logic [1:0] m_cnt = 0;
  logic [AW-3:0] m_up = 0;
  logic [DW-1:0] m_rd = 0;

  sburst_sram #(.AW(AW), .NB(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .wall_n(wall_n),
    .bwq_n(bwq_n), .bw_n(bw_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rdata_oe(rdata_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_oe();
    return !oe_n && m_rv && !m_mask;
  endfunction

  task automatic model_edge();
    logic sel, pg, cg, g, acc, wr, rd;
    logic [1:0] cn;
    logic [AW-3:0] up;
    logic [NB-1:0] be;
    sel = !sel1_n && sel2 && !sel3_n;
    pg = !pstb_n && !sel1_n;
    cg = !cstb_n && !pg;
    g = pg || cg;
    cn = g ? addr[1:0] : ((m_act && !adv_n) ? m_cnt + 2'd1 : m_cnt);
    up = g ? addr[AW-1:2] : m_up;
    acc = g ? sel : m_act;
    be = !wall_n ? '1 : (!bwq_n ? ~bw_n : '0);
    wr = acc && !pg && (be != 0);
    rd = acc && !wr;
    if (wr)
      for (int i = 0; i < NB; i++)
        if (be[i]) ref_mem[{up, cn}][8*i +: 8] = wdata[8*i +: 8];
    if (rd) m_rd = ref_mem[{up, cn}];
    m_mask = rd && !m_act;
    m_rv = rd;
    m_act = acc;
    m_cnt = cn;
    m_up = up;
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    #1;
    model_edge();
    check({tag, " oe"}, DW'(rdata_oe), DW'(exp_oe()));
    if (m_rv) check({tag, " data"}, rdata, m_rd);
  endtask

  task automatic idle();
    pstb_n = 1; cstb_n = 1; adv_n = 1; wall_n = 1; bwq_n = 1; bw_n = '1;
  endtask

  task automatic select(logic on);
    sel1_n = !on; sel2 = on; sel3_n = !on;
  endtask

  task automatic preadx(logic [AW-1:0] a);
    idle(); select(1); pstb_n = 0; addr = a;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    check("R11 reset oe", DW'(rdata_oe), '0);
    check("R11 reset data", rdata, '0);
    rst_n = 1;
    #(CLK_PERIOD);

    // R6 R5: fill array, each group of four with write-all and wrap from offset 2
    for (int g = 0; g < DEPTH / 4; g++) begin
      idle(); select(1); cstb_n = 0; wall_n = 0; addr = AW'(g * 4 + 2);
      wdata = $urandom(); tick("R6 fill start");
      for (int k = 0; k < 3; k++) begin
        idle(); wall_n = 0; bwq_n = 0; bw_n = '1; adv_n = 0; wdata = $urandom();
        tick("R5 fill step");
      end
    end

    // R6 literal write then R2 read
    idle(); select(1); cstb_n = 0; wall_n = 0; bwq_n = 1; bw_n = '1; addr = 6'd5;
    wdata = 32'hA5A5_5A5A; tick("R6 wall");
    idle(); select(0); cstb_n = 0; tick("R1 deselect");
    check("R1 no drive", DW'(rdata_oe), '0);
    preadx(6'd5); oe_n = 0; tick("R10 first read");
    check("R10 masked", DW'(rdata_oe), '0);
    check("R2 read data", rdata, 32'hA5A5_5A5A);

    // R7 partial byte write: bytes 0 and 2
    idle(); cstb_n = 0; bwq_n = 0; bw_n = 4'b1010; addr = 6'd5; wdata = 32'h1122_3344;
    tick("R7 byte write");
    preadx(6'd5); tick("R7 readback");
    check("R7 merged", rdata, 32'hA522_5A44);
    check("R9 driven", DW'(rdata_oe), 1);
    oe_n = 1; #1;
    check("R9 async off", DW'(rdata_oe), '0);
    oe_n = 0; #1;
    check("R9 async on", DW'(rdata_oe), 1);

    // R7 qualifier inactive: no write, acts as read
    idle(); cstb_n = 0; bwq_n = 1; bw_n = '0; addr = 6'd5; wdata = 32'hDEAD_BEEF;
    tick("R7 no qualifier");
    check("R7 unchanged", rdata, 32'hA522_5A44);

    // R3 R8: both strobes, write-all low -> read only
    idle(); pstb_n = 0; cstb_n = 0; wall_n = 0; addr = 6'd5; wdata = 32'h0;
    tick("R3 both strobes");
    check("R8 no write", rdata, 32'hA522_5A44);

    // R5 burst wrap 2,3,0,1 and R4 gated processor strobe
    preadx(6'd10); tick("R5 burst start");
    for (int k = 0; k < 3; k++) begin
      idle(); adv_n = 0; tick("R5 burst step");
      check("R5 address", rdata, ref_mem[6'd8 + 6'((2 + k + 1) % 4)]);
    end
    idle(); sel1_n = 1; pstb_n = 0; addr = 6'd40; tick("R4 gated strobe");
    check("R4 held", rdata, ref_mem[6'd9]);
    select(1);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 15);
      sel1_n = (r == 0); sel2 = (r != 1); sel3_n = (r == 2);
      pstb_n = ($urandom_range(0, 5) != 0);
      cstb_n = ($urandom_range(0, 5) != 0);
      adv_n = $urandom_range(0, 1);
      wall_n = ($urandom_range(0, 3) != 0);
      bwq_n = $urandom_range(0, 1);
      bw_n = NB'($urandom());
      addr = AW'($urandom());
      wdata = $urandom();
      oe_n = ($urandom_range(0, 4) == 0);
      tick("R2 R9 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule